// File: doc/BRIEF.md
# Prescaled Serial Bit-Clock Generator

This block derives a serial bit clock from the system clock for a serial port that has separate transmit and receive clock settings. Each channel holds a 16-bit clock-select value, written through a one-cycle write strobe. That value holds a 5-bit prescale field and a 3-bit power-of-two divider code. The total division is the prescale ratio multiplied by the divider ratio, from 1 up to 1024.

While a channel's run enable is high, the channel counts input cycles through one period of the total division. It produces a one-cycle bit-rate enable pulse on the last cycle of each period. It also produces a square clock output whose resting level is selected per channel. When run enable is low, the channel holds its counter at zero and parks the clock output at the resting level. Working out field values from a target frequency is left to whatever writes the select value. The block only decodes the value, flags illegal field combinations in a sticky error bit, and generates the clock. Channel 0 serves the transmit side and channel 1 the receive side. The two channels have the same layout and are fully independent.

Top module: `sclk_prescale_gen`

## Requirements
- R1: The prescale ratio is the value of select bits [12:8] plus one (1 to 32). The bit-tick period in input cycles equals the prescale ratio times the divider ratio. All other select bits outside [12:8] and [2:0] have no effect.
- R2: Divider codes in select bits [2:0] of 0, 1, 2, 3 and 4 give divider ratios of 2, 4, 8, 16 and 32.
- R3: Divider code 7 gives a divider ratio of 1 when the prescale ratio is 1 or 2.
- R4: Divider code 7 with a prescale ratio above 2 is illegal. The channel then runs with a divider ratio of 2, and its error bit is set.
- R5: Divider codes 5 and 6 are reserved. They run as a divider ratio of 32 and set the channel's error bit.
- R6: A channel's error bit rises only in the cycle after a write to that channel that carries an illegal combination. It stays high until reset, including across later legal writes.
- R7: While running, bit_tick is high for exactly one cycle at the end of each period. Counting the first output cycle after run enable is sampled high as count 0, the pulse falls on the cycles whose count modulo the period is the period minus one.
- R8: The active clock level is the inverse of idle_hi. Within each period, the clock output shows the active level for the first ceil(N/2) cycles and the idle level for the rest. For a period of 1, the output therefore stays at the active level.
- R9: One cycle after run enable is sampled low, sclk equals the idle level and bit_tick is low. The next enable restarts at count 0.
- R10: A select write takes effect at the next period start. A write sampled on the same edge as the last count of a period leaves the following period at the old length.
- R11: Channels have separate write strobes, enables, resting levels and error bits, and a write or enable on one channel does not affect the other.
- R12: Under reset, sclk, bit_tick and cfg_err are all low, and each select value returns to zero (period 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_wr | input | NCH | Per-channel select write strobe |
| sel_wdata | input | SEL_W | Select value written on a strobe |
| run_en | input | NCH | Per-channel clock output enable |
| idle_hi | input | NCH | Per-channel resting level of the clock output |
| sclk | output | NCH | Registered serial clock output |
| bit_tick | output | NCH | Registered one-cycle bit-rate enable |
| cfg_err | output | NCH | Sticky illegal-select flag |

## Verification
The two functions that can coincide are a select write and the period wrap of a running channel. The wrap reloads the period length, and the write replaces the stored length, on one edge. The bench provokes this by waiting, in its own reference model, for the last count of a period and raising the write strobe for exactly that edge. It then expects the next full period to keep the old length and the one after it to switch. A second case drops a write on the edge that starts a stopped channel, where the old value must also win. Random runs with writes at arbitrary points while running cover the same collision many more times, and each cycle is compared against the model.

// File: rtl/sclk_gen_pkg.sv
package sclk_gen_pkg;

  // Divider code field width and largest power-of-two divider exponent.
  localparam int DIV_CODE_W   = 3;
  localparam int MAX_DIV_LOG2 = 5;
  localparam int SHIFT_W      = $clog2(MAX_DIV_LOG2 + 1);

  // Divider code values; code 7 is the bypass, 5 and 6 are reserved.
  typedef enum logic [DIV_CODE_W-1:0] {
    DIV_2  = 3'd0,
    DIV_4  = 3'd1,
    DIV_8  = 3'd2,
    DIV_16 = 3'd3,
    DIV_32 = 3'd4,
    RSV_5  = 3'd5,
    RSV_6  = 3'd6,
    DIV_1  = 3'd7
  } div_code_e;

endpackage

// File: rtl/sclk_sel_reg.sv
// Holds one channel's select value in decoded form: the product of
// prescale and divider ratios, plus the sticky illegal-setting flag.
module sclk_sel_reg
  import sclk_gen_pkg::*;
#(
  parameter int SEL_W   = 16,
  parameter int PRE_W   = 5,
  parameter int PRE_LSB = 8,
  parameter int DIV_LSB = 0,
  parameter int CNT_W   = PRE_W + MAX_DIV_LOG2 + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [SEL_W-1:0] wdata,
  output logic [CNT_W-1:0] n_total,
  output logic             cfg_err
);

  localparam logic [CNT_W-1:0] RST_TOTAL = CNT_W'(2);

  logic [PRE_W:0]       pre_ratio;
  div_code_e            code;
  logic                 pre_small;
  logic [SHIFT_W-1:0]   shift;
  logic                 bad;
  logic [CNT_W-1:0]     n_new;
  logic                 unused_sel_bits;

  assign pre_ratio = {1'b0, wdata[PRE_LSB +: PRE_W]} + {{PRE_W{1'b0}}, 1'b1};
  assign code      = div_code_e'(wdata[DIV_LSB +: DIV_CODE_W]);
  assign pre_small = (pre_ratio <= (PRE_W+1)'(2));
  assign unused_sel_bits = ^wdata;

  always_comb begin
    shift = '0;
    bad   = 1'b0;
    unique case (code)
      DIV_2:  shift = SHIFT_W'(1);
      DIV_4:  shift = SHIFT_W'(2);
      DIV_8:  shift = SHIFT_W'(3);
      DIV_16: shift = SHIFT_W'(4);
      DIV_32: shift = SHIFT_W'(5);
      RSV_5, RSV_6: begin
        shift = SHIFT_W'(MAX_DIV_LOG2);
        bad   = 1'b1;
      end
      DIV_1: begin
        shift = pre_small ? SHIFT_W'(0) : SHIFT_W'(1);
        bad   = !pre_small;
      end
    endcase
  end

  assign n_new = CNT_W'(pre_ratio) << shift;

  always_ff @(posedge clk) begin
    if (rst) begin
      n_total <= RST_TOTAL;
      cfg_err <= 1'b0;
    end else if (wr) begin
      n_total <= n_new;
      if (bad) cfg_err <= 1'b1;
    end
  end

endmodule

// File: rtl/sclk_phase_core.sv
// Period counter and registered clock/tick outputs for one channel.
// The period length is taken from n_cfg only when a period starts.
module sclk_phase_core #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic             idle_hi,
  input  logic [CNT_W-1:0] n_cfg,
  output logic             sclk,
  output logic             bit_tick
);

  logic             running;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] n_cur;

  logic             restart;
  logic [CNT_W-1:0] nxt_cnt;
  logic [CNT_W-1:0] nxt_n;
  logic [CNT_W:0]   half_sum;
  logic [CNT_W-1:0] nxt_half;

  assign restart  = !running || (cnt == n_cur - CNT_W'(1));
  assign nxt_n    = restart ? n_cfg : n_cur;
  assign nxt_cnt  = restart ? '0 : cnt + CNT_W'(1);
  assign half_sum = {1'b0, nxt_n} + (CNT_W+1)'(1);
  assign nxt_half = half_sum[CNT_W:1];

  always_ff @(posedge clk) begin
    if (rst) begin
      running  <= 1'b0;
      cnt      <= '0;
      n_cur    <= CNT_W'(2);
      sclk     <= 1'b0;
      bit_tick <= 1'b0;
    end else if (!run_en) begin
      running  <= 1'b0;
      cnt      <= '0;
      sclk     <= idle_hi;
      bit_tick <= 1'b0;
    end else begin
      running  <= 1'b1;
      cnt      <= nxt_cnt;
      n_cur    <= nxt_n;
      sclk     <= idle_hi ^ (nxt_cnt < nxt_half);
      bit_tick <= (nxt_cnt == nxt_n - CNT_W'(1));
    end
  end

endmodule

// File: rtl/sclk_prescale_gen.sv
// Multi-channel prescaled bit-clock generator; channel 0 transmit,
// channel 1 receive by convention.
module sclk_prescale_gen
  import sclk_gen_pkg::*;
#(
  parameter int NCH     = 2,
  parameter int SEL_W   = 16,
  parameter int PRE_W   = 5,
  parameter int PRE_LSB = 8,
  parameter int DIV_LSB = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCH-1:0]   sel_wr,
  input  logic [SEL_W-1:0] sel_wdata,
  input  logic [NCH-1:0]   run_en,
  input  logic [NCH-1:0]   idle_hi,
  output logic [NCH-1:0]   sclk,
  output logic [NCH-1:0]   bit_tick,
  output logic [NCH-1:0]   cfg_err
);

  localparam int CNT_W = PRE_W + MAX_DIV_LOG2 + 1;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [CNT_W-1:0] n_total;

    sclk_sel_reg #(
      .SEL_W  (SEL_W),
      .PRE_W  (PRE_W),
      .PRE_LSB(PRE_LSB),
      .DIV_LSB(DIV_LSB),
      .CNT_W  (CNT_W)
    ) u_sel (
      .clk    (clk),
      .rst    (rst),
      .wr     (sel_wr[ch]),
      .wdata  (sel_wdata),
      .n_total(n_total),
      .cfg_err(cfg_err[ch])
    );

    sclk_phase_core #(
      .CNT_W(CNT_W)
    ) u_core (
      .clk     (clk),
      .rst     (rst),
      .run_en  (run_en[ch]),
      .idle_hi (idle_hi[ch]),
      .n_cfg   (n_total),
      .sclk    (sclk[ch]),
      .bit_tick(bit_tick[ch])
    );
  end

endmodule

// File: rtl/sclk_prescale_gen_chk.sv
module sclk_prescale_gen_chk #(
  parameter int NCH     = 2,
  parameter int SEL_W   = 16,
  parameter int DIV_LSB = 0
) (
  input logic             clk,
  input logic             rst,
  input logic [NCH-1:0]   sel_wr,
  input logic [SEL_W-1:0] sel_wdata,
  input logic [NCH-1:0]   run_en,
  input logic [NCH-1:0]   idle_hi,
  input logic [NCH-1:0]   sclk,
  input logic [NCH-1:0]   bit_tick,
  input logic [NCH-1:0]   cfg_err
);

  // R12: outputs quiet one cycle into reset
  p_reset_quiet_r12: assert property (@(posedge clk)
    rst |=> (sclk == '0 && bit_tick == '0 && cfg_err == '0));

  // R6: error bits never fall outside reset
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    ((cfg_err & $past(cfg_err)) == $past(cfg_err)));

  // R6: an error bit only rises after a write to its own channel
  p_err_on_write_r6: assert property (@(posedge clk) disable iff (rst)
    ((cfg_err & ~$past(cfg_err) & ~$past(sel_wr)) == '0));

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    // R9: a stopped channel parks at its idle level without ticks
    p_idle_off_r9: assert property (@(posedge clk) disable iff (rst)
      !run_en[i] |=> (sclk[i] == $past(idle_hi[i]) && !bit_tick[i]));

    // R7: a tick follows an edge where the channel was enabled
    p_tick_needs_run_r7: assert property (@(posedge clk) disable iff (rst)
      bit_tick[i] |-> $past(run_en[i]));

    // R5: a reserved divider code written raises the error bit
    p_rsv_code_err_r5: assert property (@(posedge clk) disable iff (rst)
      (sel_wr[i] && (sel_wdata[DIV_LSB +: 3] == 3'd5 ||
                     sel_wdata[DIV_LSB +: 3] == 3'd6)) |=> cfg_err[i]);
  end

endmodule

bind sclk_prescale_gen sclk_prescale_gen_chk #(
  .NCH    (NCH),
  .SEL_W  (SEL_W),
  .DIV_LSB(DIV_LSB)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .sel_wr   (sel_wr),
  .sel_wdata(sel_wdata),
  .run_en   (run_en),
  .idle_hi  (idle_hi),
  .sclk     (sclk),
  .bit_tick (bit_tick),
  .cfg_err  (cfg_err)
);

// File: tb/sclk_prescale_gen_test.sv
`timescale 1ns/1ps
module sclk_prescale_gen_test;

  localparam int NCH = 2;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NCH-1:0]  sel_wr = '0;
  logic [15:0]     sel_wdata = '0;
  logic [NCH-1:0]  run_en = '0;
  logic [NCH-1:0]  idle_hi = '0;
  logic [NCH-1:0]  sclk;
  logic [NCH-1:0]  bit_tick;
  logic [NCH-1:0]  cfg_err;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  // reference model state
  int m_cfg_n [NCH];
  int m_cnt   [NCH];
  int m_n_cur [NCH];
  bit m_run   [NCH];
  bit m_sclk  [NCH];
  bit m_tick  [NCH];
  bit m_err   [NCH];

  always #10 clk = ~clk;

  sclk_prescale_gen #(.NCH(NCH)) uut (
    .clk      (clk),
    .rst      (rst),
    .sel_wr   (sel_wr),
    .sel_wdata(sel_wdata),
    .run_en   (run_en),
    .idle_hi  (idle_hi),
    .sclk     (sclk),
    .bit_tick (bit_tick),
    .cfg_err  (cfg_err)
  );

  // total division from R1..R5
  function automatic int exp_total(logic [15:0] s);
    int p, d, code;
    p = int'(s[12:8]) + 1;
    code = int'(s[2:0]);
    case (code)
      0, 1, 2, 3, 4: d = 2 << code;
      5, 6:          d = 32;
      default:       d = (p <= 2) ? 1 : 2;
    endcase
    return p * d;
  endfunction

  function automatic bit exp_bad(logic [15:0] s);
    int p, code;
    p = int'(s[12:8]) + 1;
    code = int'(s[2:0]);
    return (code == 5) || (code == 6) || (code == 7 && p > 2);
  endfunction

  function automatic logic [15:0] mk_sel(int pre_ratio, int code, logic [15:0] junk);
    logic [15:0] s;
    s = junk;
    s[12:8] = 5'(pre_ratio - 1);
    s[2:0]  = 3'(code);
    return s;
  endfunction

  task automatic model_init();
    for (int c = 0; c < NCH; c++) begin
      m_cfg_n[c] = 2; m_cnt[c] = 0; m_n_cur[c] = 2;
      m_run[c] = 0; m_sclk[c] = 0; m_tick[c] = 0; m_err[c] = 0;
    end
  endtask

  task automatic model_edge();
    for (int c = 0; c < NCH; c++) begin
      if (run_en[c]) begin
        bit restart;
        int nn, nc;
        restart = !m_run[c] || (m_cnt[c] == m_n_cur[c] - 1);
        nn = restart ? m_cfg_n[c] : m_n_cur[c];
        nc = restart ? 0 : m_cnt[c] + 1;
        m_run[c]   = 1;
        m_cnt[c]   = nc;
        m_n_cur[c] = nn;
        m_sclk[c]  = idle_hi[c] ^ (nc < (nn + 1) / 2);
        m_tick[c]  = (nc == nn - 1);
      end else begin
        m_run[c] = 0; m_cnt[c] = 0;
        m_sclk[c] = idle_hi[c]; m_tick[c] = 0;
      end
      if (sel_wr[c]) begin
        m_cfg_n[c] = exp_total(sel_wdata);
        if (exp_bad(sel_wdata)) m_err[c] = 1;
      end
    end
  endtask

  task automatic check_bit(string tag, string what, int c, logic act, bit exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s ch%0d %s: actual=%b expected=%b at %0t", tag, c, what, act, exp, $time);
    end
  endtask

  task automatic compare(string tag);
    for (int c = 0; c < NCH; c++) begin
      check_bit(tag, "sclk", c, sclk[c], m_sclk[c]);
      check_bit(tag, "bit_tick", c, bit_tick[c], m_tick[c]);
      check_bit(tag, "cfg_err", c, cfg_err[c], m_err[c]);
    end
  endtask

  task automatic step(string tag);
    model_edge();
    @(posedge clk);
    @(negedge clk);
    sel_wr = '0;
    compare(tag);
  endtask

  task automatic run(int n, string tag);
    for (int k = 0; k < n; k++) step(tag);
  endtask

  task automatic wr_sel(int c, logic [15:0] s);
    sel_wr[c] = 1'b1;
    sel_wdata = s;
  endtask

  // configure a stopped channel, then run it for a few periods
  task automatic try_cfg(int c, logic [15:0] s, bit idle, int periods, string tag);
    run_en[c] = 1'b0;
    step(tag);
    wr_sel(c, s);
    idle_hi[c] = idle;
    step(tag);
    run_en[c] = 1'b1;
    run(periods * exp_total(s) + 2, tag);
    run_en[c] = 1'b0;
    step(tag);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    model_init();
    repeat (3) @(negedge clk);
    compare("R12");
    rst = 1'b0;

    // R12: default select value gives period 2
    step("R12");
    run_en[0] = 1'b1;
    run(9, "R12");
    run_en[0] = 1'b0;
    step("R12");

    // R2: every power-of-two divider code, two prescale ratios
    for (int code = 0; code < 5; code++) begin
      try_cfg(0, mk_sel(1, code, 16'h0), 1'b0, 3, "R2");
      try_cfg(1, mk_sel(3, code, 16'h0), 1'b1, 2, "R2");
    end

    // R1: prescale extremes with junk in the unused select bits
    try_cfg(0, mk_sel(32, 4, 16'hE0F8), 1'b0, 2, "R1");
    try_cfg(1, mk_sel(17, 1, 16'hA0A8), 1'b0, 3, "R1");
    try_cfg(0, mk_sel(32, 0, 16'h0000), 1'b1, 3, "R1");

    // R3 / R8: divide-by-1 bypass, including period 1 (odd)
    try_cfg(0, mk_sel(1, 7, 16'h0), 1'b0, 6, "R3");
    try_cfg(0, mk_sel(2, 7, 16'h0), 1'b1, 6, "R3");
    try_cfg(1, mk_sel(1, 7, 16'h0), 1'b1, 5, "R8");

    // R4 on channel 0 only; channel 1 error stays low (R11)
    try_cfg(0, mk_sel(5, 7, 16'h0), 1'b0, 3, "R4");
    try_cfg(1, mk_sel(4, 2, 16'h0), 1'b0, 2, "R11");

    // R5: reserved codes on channel 1
    try_cfg(1, mk_sel(2, 5, 16'h0), 1'b0, 2, "R5");
    try_cfg(1, mk_sel(1, 6, 16'h0), 1'b1, 2, "R5");

    // R6: legal writes do not clear the sticky flags
    try_cfg(0, mk_sel(1, 1, 16'h0), 1'b0, 2, "R6");
    try_cfg(1, mk_sel(1, 0, 16'h0), 1'b0, 2, "R6");

    // R9: stop mid-period, park, restart at count 0
    wr_sel(0, mk_sel(3, 1, 16'h0));
    idle_hi[0] = 1'b1;
    step("R9");
    run_en[0] = 1'b1;
    run(7, "R9");
    run_en[0] = 1'b0;
    run(4, "R9");
    run_en[0] = 1'b1;
    run(30, "R9");

    // R10: write in the middle of a period
    wr_sel(0, mk_sel(1, 2, 16'h0));
    step("R10");
    while (m_cnt[0] != 2) step("R10");
    wr_sel(0, mk_sel(2, 1, 16'h0));
    run(40, "R10");

    // R10: write landing on the wrap edge
    while (m_cnt[0] != m_n_cur[0] - 1) step("R10");
    wr_sel(0, mk_sel(1, 3, 16'h0));
    run(60, "R10");

    // R10: write on the edge that starts a stopped channel
    run_en[0] = 1'b0;
    step("R10");
    wr_sel(0, mk_sel(1, 0, 16'h0));
    run_en[0] = 1'b1;
    run(50, "R10");

    // R11: both channels running with different periods
    run_en = '0;
    step("R11");
    wr_sel(1, mk_sel(3, 0, 16'h0));
    step("R11");
    run_en = 2'b11;
    run(80, "R11");

    // random mix, every cycle checked against the model (R7, R8)
    for (int it = 0; it < 28; it++) begin
      int c;
      logic [15:0] s;
      c = int'($urandom % NCH);
      s = 16'($urandom);
      if ($urandom % 4 != 0) s[2:0] = 3'($urandom % 5);
      if ($urandom % 2 == 0) s[12:8] = 5'($urandom % 6);
      wr_sel(c, s);
      if ($urandom % 3 == 0) idle_hi[c] = ~idle_hi[c];
      step("R7");
      run_en[c] = 1'b1;
      run(30 + int'($urandom % 900), "R7");
      if ($urandom % 2 == 0) begin
        wr_sel(c, mk_sel(1 + int'($urandom % 4), int'($urandom % 5), 16'h0));
        run(20 + int'($urandom % 200), "R8");
      end
      if ($urandom % 3 == 0) begin
        run_en[c] = 1'b0;
        run(3, "R9");
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule